// File: doc/BRIEF.md
# Multi-Channel Event Frame Builder

This block gathers hits from 32 pulse-processing channels and packs each event into one frame: a 32-pixel map of channel energies. Every channel raises a one-cycle hit strobe together with its energy value. The first hit after an idle period opens an event window. The window closes a programmable number of clocks later. The block then streams the frame as 37 words of 32 bits over a valid/ready interface.

Every frame carries a 64-bit timestamp and a 32-bit event number. The timestamp is taken at the first hit of the event. The event number counts every event without a gap. A synchronous clear input zeroes the timestamp, the event number and the drop counter in the same cycle. When that input is driven on several boards from one wire, they share a time-zero, and their frames can be matched offline by event number. Events that arrive while an earlier frame is still waiting on the output are dropped. They are still numbered, and they are counted on `drop_count`.

Top module: `evt_frame_builder`

## Requirements
- R1: After reset, `m_valid` and `m_last` are 0 and `drop_count` is 0. The first frame carries event number 0.
- R2: A frame has 37 words in this order: word 0 = 0xFFFF in bits 31:16 with hit-mask bits 15:0 below; word 1 = hit-mask bits 31:16 in bits 15:0 with zero above; word 2 = timestamp bits 31:0; word 3 = timestamp bits 63:32; word 4 = event number; words 5..36 = energies of channels 0..31, zero-extended. `m_last` is 1 on word 36 only, and `m_valid` drops after word 36 is accepted.
- R3: When the first hit of an event is sampled at clock edge t, hits sampled at edges t through t+`win_len` belong to that event. The frame closes at edge t+`win_len`, and `m_valid` is 1 right after that edge. With `win_len` = 0, only edge t is in the window.
- R4: A channel's energy is captured when its hit strobe is sampled. A later hit on the same channel in the same window is ignored, so the first value is kept. A channel with no hit shows mask bit 0 and energy word 0.
- R5: A hit sampled after the window has closed does not join the closed frame. It starts a new event with its own frame.
- R6: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` does not change. The word index advances only on an accepted word.
- R7: An event whose first hit arrives while any word of an earlier frame is still unaccepted is dropped. `drop_count` increments by 1, no frame is produced for it, and its hits leave the pending frame unchanged.
- R8: The timestamp equals the number of clock edges from the last synchronous clear edge to the first hit edge of the event. An event that starts on the clear edge itself gets timestamp 0.
- R9: `sync_clr` zeroes the timestamp, the event number and `drop_count`. A frame already closed keeps the values it captured.
- R10: The event number increments by exactly 1 for every event, whether kept or dropped. A kept frame that follows a dropped event therefore skips one number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_clr | input | 1 | Synchronous clear of timestamp, event number and drop count |
| win_len | input | 8 | Event window length in clocks after the first hit |
| ch_hit | input | 32 | Per-channel hit strobe, one bit per channel |
| ch_energy | input | 512 | Per-channel energy, channel i in bits 16i+15:16i |
| m_ready | input | 1 | Downstream accepts the current word |
| m_valid | output | 1 | Current frame word is valid |
| m_data | output | 32 | Current frame word |
| m_last | output | 1 | Current word is the last word of the frame |
| drop_count | output | 16 | Number of events dropped since the last clear |

## Verification
The main path is tried with scattered single-channel hits spread across a window, including a hit on the last edge of the window. This separates an off-by-one window from a correct one, and a swapped mask half from a correct one. A repeated hit on one channel shows whether the first or the last energy is kept. A zero-length window checks the case where the frame closes on its first edge. A frame held back by the receiver while a second event arrives separates dropping from overwriting, and its event number shows whether the drop was still counted. A clear pulse issued while a frame waits shows that captured values survive while the counters restart. A receiver that stalls in a periodic pattern exposes any word that is skipped or repeated.

// File: rtl/efb_pkg.sv
package efb_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned TS_W      = 2 * WORD_W;
  localparam int unsigned HDR_WORDS = 5;
  localparam int unsigned MASK_LO_W = 16;
  localparam logic [15:0] HDR_TAG   = 16'hFFFF;

  typedef enum logic [0:0] {
    CS_IDLE = 1'b0,
    CS_WIN  = 1'b1
  } coll_state_e;
endpackage

// File: rtl/efb_rst_sync.sv
module efb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/efb_timebase.sv
module efb_timebase
  import efb_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic              evt_start,
  input  logic              evt_drop,
  output logic [TS_W-1:0]   ts_now,
  output logic [CNT_W-1:0]  cnt_now,
  output logic [DROP_W-1:0] drop_cnt
);
  logic [TS_W-1:0]   ts_q, ts_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic [DROP_W-1:0] drop_base;

  // The clear edge itself is time zero: values seen on that edge are zero.
  assign ts_now    = sync_clr ? '0 : ts_q;
  assign cnt_now   = sync_clr ? '0 : cnt_q;
  assign drop_base = sync_clr ? '0 : drop_q;

  always_comb begin
    ts_d   = ts_now + TS_W'(1);
    cnt_d  = evt_start ? cnt_now + CNT_W'(1) : cnt_now;
    drop_d = evt_drop ? drop_base + DROP_W'(1) : drop_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q   <= '0;
      cnt_q  <= '0;
      drop_q <= '0;
    end else begin
      ts_q   <= ts_d;
      cnt_q  <= cnt_d;
      drop_q <= drop_d;
    end
  end

  assign drop_cnt = drop_q;

  // R9: a clear with no new drop leaves the drop counter at zero
  a_r9_drop_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_clr && !evt_drop) |=> (drop_cnt == '0));
endmodule

// File: rtl/efb_collector.sv
module efb_collector
  import efb_pkg::*;
#(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned E_W   = 16,
  parameter int unsigned WIN_W = 8,
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_W-1:0]  win_len,
  input  logic [N_CH-1:0]   ch_hit,
  input  logic [N_CH*E_W-1:0] ch_energy,
  input  logic              tx_busy,
  input  logic [TS_W-1:0]   ts_now,
  input  logic [CNT_W-1:0]  cnt_now,
  output logic              evt_start,
  output logic              evt_drop,
  output logic              close_fire,
  output logic [N_CH-1:0]   hit_mask,
  output logic [N_CH*E_W-1:0] energy,
  output logic [TS_W-1:0]   evt_ts,
  output logic [CNT_W-1:0]  evt_id
);
  coll_state_e      state_q, state_d;
  logic [WIN_W-1:0] elapsed_q, elapsed_d;
  logic             discard_q, discard_d;
  logic             keep;
  logic             live;
  logic [N_CH-1:0]  mask_q, mask_d;
  logic [N_CH-1:0]  en_load;
  logic [TS_W-1:0]  ts_q;
  logic [CNT_W-1:0] id_q;

  assign evt_start = (state_q == CS_IDLE) && (|ch_hit);
  assign evt_drop  = evt_start && tx_busy;
  assign keep      = evt_start && !tx_busy;
  assign live      = (state_q == CS_WIN) && !discard_q;

  always_comb begin
    state_d    = state_q;
    elapsed_d  = elapsed_q;
    discard_d  = discard_q;
    close_fire = 1'b0;
    if (evt_start) begin
      discard_d = tx_busy;
      if (win_len == '0) begin
        state_d    = CS_IDLE;
        close_fire = !tx_busy;
      end else begin
        state_d   = CS_WIN;
        elapsed_d = WIN_W'(1);
      end
    end else if (state_q == CS_WIN) begin
      if (elapsed_q >= win_len) begin
        state_d    = CS_IDLE;
        close_fire = !discard_q;
      end else begin
        elapsed_d = elapsed_q + WIN_W'(1);
      end
    end
  end

  always_comb begin
    if (keep)      mask_d = ch_hit;
    else if (live) mask_d = mask_q | ch_hit;
    else           mask_d = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CS_IDLE;
      elapsed_q <= '0;
      discard_q <= 1'b0;
      mask_q    <= '0;
    end else begin
      state_q   <= state_d;
      elapsed_q <= elapsed_d;
      discard_q <= discard_d;
      mask_q    <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q <= '0;
      id_q <= '0;
    end else if (keep) begin
      ts_q <= ts_now;
      id_q <= cnt_now;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [E_W-1:0] en_q;
    assign en_load[i] = keep ? ch_hit[i] : (live && ch_hit[i] && !mask_q[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_q <= '0;
      else if (en_load[i]) en_q <= ch_energy[i*E_W +: E_W];
    end
    assign energy[i*E_W +: E_W] = en_q;
  end

  assign hit_mask = mask_q;
  assign evt_ts   = ts_q;
  assign evt_id   = id_q;

  // R4: inside a live window the hit mask only gains bits
  a_r4_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> ((hit_mask & $past(hit_mask)) == $past(hit_mask)));

  // R7: nothing of the pending frame changes while it is being sent
  a_r7_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> ($stable(hit_mask) && $stable(energy) && $stable(evt_id)));
endmodule

// File: rtl/efb_serializer.sv
module efb_serializer
  import efb_pkg::*;
#(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned E_W   = 16,
  parameter int unsigned CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                close_fire,
  input  logic [N_CH-1:0]     hit_mask,
  input  logic [N_CH*E_W-1:0] energy,
  input  logic [TS_W-1:0]     evt_ts,
  input  logic [CNT_W-1:0]    evt_id,
  input  logic                m_ready,
  output logic                m_valid,
  output logic [WORD_W-1:0]   m_data,
  output logic                m_last,
  output logic                tx_busy
);
  localparam int unsigned FRAME_WORDS = HDR_WORDS + N_CH;
  localparam int unsigned IDX_W       = $clog2(FRAME_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [WORD_W-1:0] word_arr [FRAME_WORDS];

  assign word_arr[0] = {HDR_TAG, hit_mask[MASK_LO_W-1:0]};
  assign word_arr[1] = WORD_W'(hit_mask >> MASK_LO_W);
  assign word_arr[2] = evt_ts[WORD_W-1:0];
  assign word_arr[3] = evt_ts[TS_W-1:WORD_W];
  assign word_arr[4] = WORD_W'(evt_id);

  for (genvar i = 0; i < N_CH; i++) begin : g_word
    assign word_arr[HDR_WORDS+i] =
      hit_mask[i] ? WORD_W'(energy[i*E_W +: E_W]) : '0;
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (close_fire) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q && m_ready) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign tx_busy = busy_q;
  assign m_valid = busy_q;
  assign m_data  = word_arr[idx_q];
  assign m_last  = busy_q && (idx_q == LAST_IDX);

  // R6: a stalled word is held
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R2: the frame ends after its last word is taken
  a_r2_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> !m_valid);

  // R3: output becomes valid only after a window closed
  a_r3_rise_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(close_fire));
endmodule

// File: rtl/evt_frame_builder.sv
module evt_frame_builder
  import efb_pkg::*;
#(
  parameter int unsigned N_CH   = 32,
  parameter int unsigned E_W    = 16,
  parameter int unsigned WIN_W  = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DROP_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_clr,
  input  logic [WIN_W-1:0]    win_len,
  input  logic [N_CH-1:0]     ch_hit,
  input  logic [N_CH*E_W-1:0] ch_energy,
  input  logic                m_ready,
  output logic                m_valid,
  output logic [WORD_W-1:0]   m_data,
  output logic                m_last,
  output logic [DROP_W-1:0]   drop_count
);
  logic               rst_n_sync;
  logic               evt_start, evt_drop, close_fire, tx_busy;
  logic [TS_W-1:0]    ts_now, evt_ts;
  logic [CNT_W-1:0]   cnt_now, evt_id;
  logic [N_CH-1:0]    hit_mask;
  logic [N_CH*E_W-1:0] energy;

  efb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  efb_timebase #(.CNT_W(CNT_W), .DROP_W(DROP_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .sync_clr  (sync_clr),
    .evt_start (evt_start),
    .evt_drop  (evt_drop),
    .ts_now    (ts_now),
    .cnt_now   (cnt_now),
    .drop_cnt  (drop_count)
  );

  efb_collector #(.N_CH(N_CH), .E_W(E_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_col (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .win_len    (win_len),
    .ch_hit     (ch_hit),
    .ch_energy  (ch_energy),
    .tx_busy    (tx_busy),
    .ts_now     (ts_now),
    .cnt_now    (cnt_now),
    .evt_start  (evt_start),
    .evt_drop   (evt_drop),
    .close_fire (close_fire),
    .hit_mask   (hit_mask),
    .energy     (energy),
    .evt_ts     (evt_ts),
    .evt_id     (evt_id)
  );

  efb_serializer #(.N_CH(N_CH), .E_W(E_W), .CNT_W(CNT_W)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .close_fire (close_fire),
    .hit_mask   (hit_mask),
    .energy     (energy),
    .evt_ts     (evt_ts),
    .evt_id     (evt_id),
    .m_ready    (m_ready),
    .m_valid    (m_valid),
    .m_data     (m_data),
    .m_last     (m_last),
    .tx_busy    (tx_busy)
  );

  // R10: a dropped event never produces a frame close in the same cycle
  a_r10_drop_no_close: assert property (@(posedge clk) disable iff (!rst_n_sync)
    evt_drop |-> !close_fire);
endmodule

// File: tb/tb_evt_frame_builder.sv
module tb_evt_frame_builder;
  logic         clk;
  logic         rst_n;
  logic         sync_clr;
  logic [7:0]   win_len;
  logic [31:0]  ch_hit;
  logic [511:0] ch_energy;
  logic         m_ready;
  logic         m_valid;
  logic [31:0]  m_data;
  logic         m_last;
  logic [15:0]  drop_count;

  logic [15:0]  en_in [32];
  logic [31:0]  exp_words [37];
  logic [15:0]  exp_en [32];
  logic [31:0]  got [37];
  logic         got_last [37];

  int checks = 0;
  int fails = 0;
  int edge_no = 0;
  int base_edge = 0;
  int next_id = 0;
  bit done = 0;

  evt_frame_builder dut (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .win_len(win_len),
    .ch_hit(ch_hit), .ch_energy(ch_energy), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .m_last(m_last),
    .drop_count(drop_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 32; i++) ch_energy[i*16 +: 16] = en_in[i];
  end

  always @(posedge clk) begin
    edge_no <= edge_no + 1;
    if (edge_no == 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: cycles=%0d expected < %0d", edge_no, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic apply_hits(input logic [31:0] m, input logic [15:0] tag);
    ch_hit = m;
    for (int i = 0; i < 32; i++) en_in[i] = tag + 16'(i);
    @(negedge clk);
    ch_hit = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 32; i++) exp_en[i] = '0;
  endtask

  task automatic build_exp(input logic [31:0] mask, input logic [63:0] ts,
                           input logic [31:0] id);
    exp_words[0] = {16'hFFFF, mask[15:0]};
    exp_words[1] = {16'h0000, mask[31:16]};
    exp_words[2] = ts[31:0];
    exp_words[3] = ts[63:32];
    exp_words[4] = id;
    for (int i = 0; i < 32; i++) exp_words[5+i] = mask[i] ? {16'h0, exp_en[i]} : 32'h0;
  endtask

  // mode 0: always ready; mode 1: ready low every third cycle
  task automatic recv_frame(input int mode, input string req);
    int n = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic [31:0] prev_data = '0;
    bit r;
    while (n < 37 && cyc < 400) begin
      if (prev_stall)
        chk(m_valid && (m_data == prev_data), "R6", "held word",
            {31'h0, m_valid, m_data}, {31'h0, 1'b1, prev_data});
      r = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      m_ready = r;
      if (m_valid && r) begin
        got[n] = m_data;
        got_last[n] = m_last;
        n++;
      end
      prev_stall = m_valid && !r;
      prev_data = m_data;
      @(negedge clk);
      cyc++;
    end
    m_ready = 1'b0;
    chk(n == 37, req, "word count", 64'(n), 64'd37);
    chk(!m_valid, "R2", "valid after last word", 64'(m_valid), 64'd0);
    for (int i = 0; i < 37; i++) begin
      chk(got[i] == exp_words[i], req, $sformatf("word %0d", i), 64'(got[i]), 64'(exp_words[i]));
      chk(got_last[i] == (i == 36), "R2", $sformatf("last flag word %0d", i),
          64'(got_last[i]), 64'(i == 36));
    end
  endtask

  task automatic do_sync();
    base_edge = edge_no + 1;
    next_id = 0;
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(!m_valid, "R1", "m_valid after reset", 64'(m_valid), 64'd0);
    chk(!m_last, "R1", "m_last after reset", 64'(m_last), 64'd0);
    chk(drop_count == 0, "R1", "drop_count after reset", 64'(drop_count), 64'd0);
  endtask

  // R3 window edges, R2 layout, R8 timestamp, R1 first id
  task automatic t_basic();
    int te;
    logic [31:0] mask;
    win_len = 8'd3;
    idle(3);
    clear_exp();
    te = edge_no + 1;
    apply_hits(32'h0000_0021, 16'h1000);
    apply_hits(32'h0002_0000, 16'h2000);
    chk(!m_valid, "R3", "valid inside window +1", 64'(m_valid), 64'd0);
    apply_hits(32'h0, 16'h0);
    chk(!m_valid, "R3", "valid inside window +2", 64'(m_valid), 64'd0);
    apply_hits(32'h8000_0000, 16'h3000);
    chk(m_valid, "R3", "valid after window close", 64'(m_valid), 64'd1);
    exp_en[0] = 16'h1000; exp_en[5] = 16'h1005;
    exp_en[17] = 16'h2011; exp_en[31] = 16'h301F;
    mask = 32'h8002_0021;
    build_exp(mask, 64'(te - base_edge), 32'(next_id));
    next_id++;
    recv_frame(0, "R2");
  endtask

  // R4 duplicate hit keeps first value; R6 stall pattern
  task automatic t_dup_stall();
    int te;
    win_len = 8'd2;
    idle(2);
    clear_exp();
    te = edge_no + 1;
    apply_hits(32'h0000_0008, 16'h1100);
    apply_hits(32'h0000_0008, 16'h2200);
    idle(1);
    exp_en[3] = 16'h1103;
    build_exp(32'h0000_0008, 64'(te - base_edge), 32'(next_id));
    next_id++;
    recv_frame(1, "R4");
  endtask

  // R7 drop while pending, R10 numbering gap
  task automatic t_drop();
    int ta;
    int ida;
    logic [15:0] d0;
    win_len = 8'd2;
    idle(2);
    d0 = drop_count;
    clear_exp();
    ta = edge_no + 1;
    apply_hits(32'h0000_0002, 16'hA000);
    idle(2);
    chk(m_valid, "R7", "frame A pending", 64'(m_valid), 64'd1);
    ida = next_id;
    next_id++;
    apply_hits(32'h0000_0006, 16'hB000);
    next_id++;
    idle(3);
    chk(drop_count == d0 + 16'd1, "R7", "drop_count", 64'(drop_count), 64'(d0 + 16'd1));
    exp_en[1] = 16'hA001;
    build_exp(32'h0000_0002, 64'(ta - base_edge), 32'(ida));
    recv_frame(0, "R7");
    idle(1);
    clear_exp();
    ta = edge_no + 1;
    apply_hits(32'h0000_0200, 16'hC000);
    idle(2);
    exp_en[9] = 16'hC009;
    build_exp(32'h0000_0200, 64'(ta - base_edge), 32'(ida + 2));
    next_id++;
    recv_frame(0, "R10");
  endtask

  // R3 zero-length window
  task automatic t_zero_win();
    int te;
    win_len = 8'd0;
    idle(2);
    clear_exp();
    te = edge_no + 1;
    apply_hits(32'h0000_0080, 16'h0700);
    chk(m_valid, "R3", "zero window closes at once", 64'(m_valid), 64'd1);
    exp_en[7] = 16'h0707;
    build_exp(32'h0000_0080, 64'(te - base_edge), 32'(next_id));
    next_id++;
    recv_frame(0, "R3");
  endtask

  // R5 hit after close starts a new frame
  task automatic t_new_event();
    int te;
    win_len = 8'd1;
    idle(2);
    clear_exp();
    te = edge_no + 1;
    apply_hits(32'h0000_0400, 16'h0A00);
    apply_hits(32'h0000_0800, 16'h0B00);
    chk(m_valid, "R5", "first frame closed", 64'(m_valid), 64'd1);
    exp_en[10] = 16'h0A0A; exp_en[11] = 16'h0B0B;
    build_exp(32'h0000_0C00, 64'(te - base_edge), 32'(next_id));
    next_id++;
    recv_frame(0, "R5");
    clear_exp();
    te = edge_no + 1;
    apply_hits(32'h0000_1000, 16'h0C00);
    idle(1);
    exp_en[12] = 16'h0C0C;
    build_exp(32'h0000_1000, 64'(te - base_edge), 32'(next_id));
    next_id++;
    recv_frame(0, "R5");
  endtask

  // R9 clear while a frame waits; R8 timestamp restarts
  task automatic t_sync();
    int te;
    logic [63:0] old_ts;
    int old_id;
    win_len = 8'd1;
    idle(2);
    clear_exp();
    te = edge_no + 1;
    apply_hits(32'h0000_0010, 16'h0400);
    idle(1);
    old_ts = 64'(te - base_edge);
    old_id = next_id;
    exp_en[4] = 16'h0404;
    do_sync();
    idle(1);
    chk(drop_count == 0, "R9", "drop_count cleared", 64'(drop_count), 64'd0);
    build_exp(32'h0000_0010, old_ts, 32'(old_id));
    recv_frame(0, "R9");
    idle(3);
    clear_exp();
    te = edge_no + 1;
    apply_hits(32'h0001_0000, 16'h1600);
    idle(1);
    exp_en[16] = 16'h1610;
    build_exp(32'h0001_0000, 64'(te - base_edge), 32'(next_id));
    next_id++;
    recv_frame(0, "R8");
  endtask

  initial begin
    rst_n = 1'b0;
    sync_clr = 1'b0;
    win_len = 8'd1;
    ch_hit = '0;
    m_ready = 1'b0;
    for (int i = 0; i < 32; i++) en_in[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    do_sync();
    t_basic();
    t_dup_stall();
    t_drop();
    t_zero_win();
    t_new_event();
    t_sync();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule